// File: doc/BRIEF.md
# Frame-Rate Character Blink Timer

This block produces one blink-visible signal shared by every blinking character of an on-screen display overlay. It counts frames by watching the vertical sync input. The output is high for the leading part of each blink period and low for the rest. The character pixel path combines the signal with each character's own blink attribute, and that path lies outside this block.

The blink period is a power-of-two number of frames, chosen by a 2-bit select. A second 2-bit select sets how the period splits between visible and hidden time. Both settings apply to the whole frame. A new setting takes effect only when a period restarts, so a period already running is never cut short. The input sync can be active high or active low. It is synchronised to the block clock before its leading edge is detected, and only the transition into the active level counts as a frame.

Top module: `blink_gen`

## Requirements
- R1: With `vsync_act_high`=1 a frame is counted on a low-to-high transition of `vsync_in`. With `vsync_act_high`=0 a frame is counted on a high-to-low transition. The return to the idle level counts nothing.
- R2: The frame count rises by one per counted frame and returns to 0 after D frames, where D = 16 << `period_sel` (00=16, 01=32, 10=64, 11=128). After exactly D frames the output is back at its start-of-period value.
- R3: With `ratio_sel` 00 or 11 (even split), `blink_on` is 1 while the frame count is below D/2 and 0 otherwise.
- R4: With `ratio_sel` 01 (one on, three off), `blink_on` is 1 while the frame count is below D/4.
- R5: With `ratio_sel` 10 (three on, one off), `blink_on` is 1 while the frame count is below 3*D/4.
- R6: Values on `period_sel` and `ratio_sel` are taken in only while the frame count is 0. A change made later in a period first has effect once the count has wrapped.
- R7: Reset clears the frame count, and `blink_on` is 1 when reset is released.
- R8: A sync pulse held active for many clock cycles counts as exactly one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vsync_in | input | 1 | Vertical sync, asynchronous to clk |
| vsync_act_high | input | 1 | 1: sync active high, 0: active low |
| period_sel | input | 2 | Blink period select, D = 16 << value frames |
| ratio_sel | input | 2 | Visible/hidden split select |
| blink_on | output | 1 | 1 when blinking characters are shown |

## Verification
The bound checker runs on every cycle. It checks that the frame count moves only on a one-cycle detected edge and then by exactly one, that it wraps at the limit given by the captured period and never passes it, that the captured settings stay frozen while the count is nonzero, and that the output is visible at the start of each period. The bench's scenarios are needed for the rest: the visible fraction for each split, the divisor for each period select, the deferral of mid-period changes, how long pulses count, and both sync polarities. All of these depend on whole sequences of frames and are seen only at `blink_on`.

// File: rtl/blink_pkg.sv
package blink_pkg;

    typedef enum logic [1:0] {
        SPLIT_HALF    = 2'b00,
        SPLIT_QUARTER = 2'b01,
        SPLIT_THREE_Q = 2'b10,
        SPLIT_HALF_B  = 2'b11
    } blink_split_e;

endpackage

// File: rtl/blink_vsync_edge.sv
module blink_vsync_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_in,
    input  logic act_high,
    output logic frame_edge
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic        active_lvl;

    // Normalise before synchronising so reset (all zero) means "inactive".
    assign active_lvl = (vsync_in == act_high);

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = active_lvl;
        for (int i = 1; i < int'(SYNC_STAGES); i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.prev    = st_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_edge = st_q.sync[SYNC_STAGES-1] & ~st_q.prev;

endmodule

// File: rtl/blink_frame_counter.sv
module blink_frame_counter
    import blink_pkg::*;
#(
    parameter int unsigned MIN_LOG2 = 4,
    parameter int unsigned PSEL_W   = 2,
    localparam int unsigned CNT_W   = MIN_LOG2 + (1 << PSEL_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_edge,
    input  logic [PSEL_W-1:0] period_sel,
    input  blink_split_e      split_sel,
    output logic [CNT_W-1:0]  cnt,
    output logic [PSEL_W-1:0] psel_cur,
    output blink_split_e      split_cur
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [PSEL_W-1:0] psel;
        blink_split_e      split;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [CNT_W:0]   divisor;
    logic [CNT_W-1:0] last_cnt;
    logic             at_last;

    assign divisor  = (CNT_W+1)'(1) << (MIN_LOG2 + int'(st_q.psel));
    assign last_cnt = CNT_W'(divisor - (CNT_W+1)'(1));
    assign at_last  = (st_q.cnt == last_cnt);

    always_comb begin
        st_d = st_q;
        // Settings follow the inputs only during the first frame of a period.
        if (st_q.cnt == '0) begin
            st_d.psel  = period_sel;
            st_d.split = split_sel;
        end
        if (frame_edge) begin
            st_d.cnt = at_last ? '0 : st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, psel: '0, split: SPLIT_HALF};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt       = st_q.cnt;
    assign psel_cur  = st_q.psel;
    assign split_cur = st_q.split;

endmodule

// File: rtl/blink_split_cmp.sv
module blink_split_cmp
    import blink_pkg::*;
#(
    parameter int unsigned MIN_LOG2 = 4,
    parameter int unsigned PSEL_W   = 2,
    localparam int unsigned CNT_W   = MIN_LOG2 + (1 << PSEL_W) - 1
) (
    input  logic [CNT_W-1:0]  cnt,
    input  logic [PSEL_W-1:0] psel,
    input  blink_split_e      split,
    output logic              visible
);

    logic [CNT_W:0] divisor;
    logic [CNT_W:0] half_lim;
    logic [CNT_W:0] quarter_lim;
    logic [CNT_W:0] limit;

    assign divisor     = (CNT_W+1)'(1) << (MIN_LOG2 + int'(psel));
    assign half_lim    = divisor >> 1;
    assign quarter_lim = divisor >> 2;

    always_comb begin
        unique case (split)
            SPLIT_QUARTER: limit = quarter_lim;
            SPLIT_THREE_Q: limit = half_lim + quarter_lim;
            default:       limit = half_lim;
        endcase
    end

    assign visible = ({1'b0, cnt} < limit);

endmodule

// File: rtl/blink_gen.sv
module blink_gen
    import blink_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_LOG2    = 4,
    parameter int unsigned PSEL_W      = 2,
    localparam int unsigned CNT_W      = MIN_LOG2 + (1 << PSEL_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_in,
    input  logic              vsync_act_high,
    input  logic [PSEL_W-1:0] period_sel,
    input  logic [1:0]        ratio_sel,
    output logic              blink_on
);

    logic              frame_edge;
    logic [CNT_W-1:0]  cnt;
    logic [PSEL_W-1:0] psel_cur;
    blink_split_e      split_cur;

    blink_vsync_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync_in  (vsync_in),
        .act_high  (vsync_act_high),
        .frame_edge(frame_edge)
    );

    blink_frame_counter #(
        .MIN_LOG2(MIN_LOG2),
        .PSEL_W  (PSEL_W)
    ) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_edge(frame_edge),
        .period_sel(period_sel),
        .split_sel (blink_split_e'(ratio_sel)),
        .cnt       (cnt),
        .psel_cur  (psel_cur),
        .split_cur (split_cur)
    );

    blink_split_cmp #(
        .MIN_LOG2(MIN_LOG2),
        .PSEL_W  (PSEL_W)
    ) i_cmp (
        .cnt    (cnt),
        .psel   (psel_cur),
        .split  (split_cur),
        .visible(blink_on)
    );

endmodule

// File: rtl/blink_gen_chk.sv
module blink_gen_chk
    import blink_pkg::*;
#(
    parameter int unsigned MIN_LOG2 = 4,
    parameter int unsigned PSEL_W   = 2,
    localparam int unsigned CNT_W   = MIN_LOG2 + (1 << PSEL_W) - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_edge,
    input logic [CNT_W-1:0]  cnt,
    input logic [PSEL_W-1:0] psel_cur,
    input blink_split_e      split_cur,
    input logic              blink_on
);

    logic [CNT_W:0]   lim_div;
    logic [CNT_W-1:0] lim_last;

    assign lim_div  = (CNT_W+1)'(1) << (MIN_LOG2 + int'(psel_cur));
    assign lim_last = CNT_W'(lim_div - (CNT_W+1)'(1));

    a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim_last);

    a_r2_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_edge |=> $stable(cnt));

    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_edge && cnt != lim_last) |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

    a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_edge && cnt == lim_last) |=> cnt == '0);

    a_r6_settings_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> ($stable(psel_cur) && $stable(split_cur)));

    a_r7_period_start_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> blink_on);

    a_r8_edge_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_edge |=> !frame_edge);

endmodule

bind blink_gen blink_gen_chk #(
    .MIN_LOG2(MIN_LOG2),
    .PSEL_W  (PSEL_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_edge(frame_edge),
    .cnt       (cnt),
    .psel_cur  (psel_cur),
    .split_cur (split_cur),
    .blink_on  (blink_on)
);

// File: tb/test_blink_gen.sv
module test_blink_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsync_in = 1'b0;
    logic       vsync_act_high = 1'b1;
    logic [1:0] period_sel = 2'b00;
    logic [1:0] ratio_sel = 2'b00;
    logic       blink_on;

    int n_checks = 0;
    int n_errors = 0;
    logic act_lvl = 1'b1;

    always #5 clk = ~clk;

    blink_gen i_blink_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .vsync_in      (vsync_in),
        .vsync_act_high(vsync_act_high),
        .period_sel    (period_sel),
        .ratio_sel     (ratio_sel),
        .blink_on      (blink_on)
    );

    function automatic logic exp_vis(int k, int psel, int rsel);
        int div;
        int thr;
        div = 16 << psel;
        if (rsel == 1)      thr = div / 4;
        else if (rsel == 2) thr = (3 * div) / 4;
        else                thr = div / 2;
        return ((k % div) < thr);
    endfunction

    task automatic expect_vis(logic exp, string tag, int frame);
        n_checks++;
        if (blink_on !== exp) begin
            n_errors++;
            $display("FAIL %s frame %0d: blink_on=%b expected %b", tag, frame, blink_on, exp);
        end
    endtask

    task automatic reset_dut(logic pol);
        @(negedge clk);
        rst_n          = 1'b0;
        act_lvl        = pol;
        vsync_act_high = pol;
        vsync_in       = ~pol;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse(int len);
        vsync_in = act_lvl;
        repeat (len) @(negedge clk);
        vsync_in = ~act_lvl;
        repeat (5) @(negedge clk);
    endtask

    // R7: reset state
    task automatic t_reset();
        reset_dut(1'b1);
        expect_vis(1'b1, "R7", 0);
        repeat (10) @(negedge clk);
        expect_vis(1'b1, "R7", 0);
    endtask

    // R2 and R3: one full period for each period select, even split
    task automatic t_periods();
        for (int p = 0; p < 4; p++) begin
            reset_dut(1'b1);
            period_sel = 2'(p);
            ratio_sel  = 2'b00;
            @(negedge clk);
            for (int k = 1; k <= (16 << p); k++) begin
                pulse(2);
                expect_vis(exp_vis(k, p, 0), (k == (16 << p)) ? "R2" : "R3", k);
            end
            pulse(2);
            expect_vis(exp_vis(1, p, 0), "R2", (16 << p) + 1);
        end
    endtask

    // R3 (code 11), R4 and R5 at period 16 and 64
    task automatic t_splits();
        for (int r = 1; r < 4; r++) begin
            for (int p = 0; p < 3; p += 2) begin
                reset_dut(1'b1);
                period_sel = 2'(p);
                ratio_sel  = 2'(r);
                @(negedge clk);
                for (int k = 1; k <= (16 << p); k++) begin
                    pulse(2);
                    expect_vis(exp_vis(k, p, r),
                               (r == 1) ? "R4" : (r == 2) ? "R5" : "R3", k);
                end
            end
        end
    endtask

    // R6: changes mid-period are deferred to the wrap
    task automatic t_defer();
        reset_dut(1'b1);
        period_sel = 2'b00;
        ratio_sel  = 2'b00;
        @(negedge clk);
        for (int k = 1; k <= 4; k++) pulse(2);
        period_sel = 2'b11;
        ratio_sel  = 2'b01;
        for (int k = 5; k <= 16; k++) begin
            pulse(2);
            expect_vis(exp_vis(k, 0, 0), "R6", k);
        end
        for (int k = 1; k <= 40; k++) begin
            pulse(2);
            expect_vis(exp_vis(k, 3, 1), "R6", 16 + k);
        end
    endtask

    // R8: long pulses count once
    task automatic t_long();
        reset_dut(1'b1);
        period_sel = 2'b00;
        ratio_sel  = 2'b00;
        @(negedge clk);
        for (int k = 1; k <= 9; k++) begin
            pulse(40);
            expect_vis(exp_vis(k, 0, 0), "R8", k);
        end
    endtask

    // R1: active-low sync
    task automatic t_polarity();
        reset_dut(1'b0);
        expect_vis(1'b1, "R1", 0);
        period_sel = 2'b00;
        ratio_sel  = 2'b01;
        @(negedge clk);
        for (int k = 1; k <= 16; k++) begin
            pulse(3);
            expect_vis(exp_vis(k, 0, 1), "R1", k);
        end
        reset_dut(1'b1);
        period_sel = 2'b00;
        ratio_sel  = 2'b01;
        @(negedge clk);
        for (int k = 1; k <= 5; k++) begin
            pulse(3);
            expect_vis(exp_vis(k, 0, 1), "R1", k);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run incomplete, expected finish before timeout");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        t_reset();
        t_periods();
        t_splits();
        t_defer();
        t_long();
        t_polarity();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule